// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block watches the boundary between the decode and execute stages of a small five-stage pipelined processor with eight registers. Each cycle it compares the instruction word that sits in the decode-stage register with the instruction word it holds for the execute stage. If the execute-stage instruction is a load, and the register the load writes is one the decode-stage instruction names as a source, the block raises a stall in the same cycle. The stall holds the program counter and the decode-stage register, and a no-op bubble goes into the execute stage instead of the instruction in decode.

The block owns the execute-stage instruction register. On each clock edge that register takes either the decode-stage word unchanged or the fixed bubble word. After one stall cycle the load has moved on and the bubble is a no-op, so a hazard always costs exactly one cycle. The stall, the two write enables and the next execute-stage word are all combinational. They are available to the surrounding datapath in the same cycle.

Reset is asserted asynchronously and released synchronously through a short synchronizer inside the block. While reset is active, and until the synchronizer releases it, the execute-stage register holds the bubble word.

Top module: `lus_stall_unit`

## Requirements
- R1: While reset is active, and after it is released until the first decode word is taken, `idex_instr` equals the bubble word 0x01C00000 (opcode 7 in bits [24:22], all other bits zero) and `stall` is 0.
- R2: `stall` is 1 in the same cycle when `idex_instr[24:22]` is 2 (load) and `idex_instr[18:16]` equals `ifid_instr[21:19]`.
- R3: `stall` is 1 in the same cycle when `idex_instr[24:22]` is 2 and `idex_instr[18:16]` equals `ifid_instr[18:16]`.
- R4: `stall` is 0 whenever `idex_instr[24:22]` is not 2. This covers add (0), nor (1), store (3), branch (4) and the bubble (7), even when their register fields match.
- R5: With a load in execute, `stall` is 0 when its bits [18:16] match neither source field of the decode word. The low 16-bit field `ifid_instr[15:0]` is never compared.
- R6: A decode word whose opcode is halt (6) or no-op (7) is still compared, and it stalls on a field match.
- R7: `pc_write_en` and `ifid_write_en` are both the inverse of `stall` in the same cycle.
- R8: `idex_instr_nxt` is the bubble word when `stall` is 1, and otherwise equals `ifid_instr`. `idex_instr` takes that value on the next rising clock edge.
- R9: When the decode word is held across a stall, the following cycle has `stall` at 0 and `idex_instr` equal to the bubble. Every hazard therefore lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ifid_instr | input | 32 | Instruction word in the decode-stage register |
| stall | output | 1 | Load-use hazard detected this cycle |
| pc_write_en | output | 1 | Program counter update enable (low on stall) |
| ifid_write_en | output | 1 | Decode-stage register update enable (low on stall) |
| idex_instr_nxt | output | 32 | Word the execute-stage register takes at the next edge |
| idex_instr | output | 32 | Current execute-stage instruction word |

## Verification
Each hazard path is tried on its own. A load whose destination matches only the decode word's first source field tells the R2 compare apart from the R3 compare, and the reverse case does the same the other way round. Near misses separate the real compare from over-eager ones: a non-load that has matching fields, a load matched only by the decode word's low 16-bit field, and the bubble's zero field against a decode word that uses register 0. Held decode words after a stall, halt and no-op decode words, and back-to-back loads show that the bubble is inserted, that each stall lasts exactly one cycle, and that the pipeline then resumes with the held word.

// File: rtl/lus_pkg.sv
package lus_pkg;
  localparam int OP_W     = 3;
  localparam int REG_W    = 3;
  localparam int OFF_W    = 16;
  localparam int REGB_LSB = OFF_W;
  localparam int REGA_LSB = OFF_W + REG_W;
  localparam int OP_LSB   = OFF_W + 2 * REG_W;
  localparam int FMT_W    = OP_LSB + OP_W;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 3'd0,
    OP_NOR   = 3'd1,
    OP_LOAD  = 3'd2,
    OP_STORE = 3'd3,
    OP_BEQ   = 3'd4,
    OP_JALR  = 3'd5,
    OP_HALT  = 3'd6,
    OP_NOP   = 3'd7
  } opcode_e;
endpackage

// File: rtl/lus_rst_sync.sv
module lus_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/lus_stall_detect.sv
module lus_stall_detect
  import lus_pkg::*;
#(
  parameter bit CMP_SRC_B = 1'b1
) (
  input  logic [OP_W-1:0]  ex_op,
  input  logic [REG_W-1:0] ex_dst,
  input  logic [REG_W-1:0] id_src_a,
  input  logic [REG_W-1:0] id_src_b,
  output logic             hazard
);
  logic is_load;
  logic hit_a;
  logic hit_b;

  assign is_load = (ex_op == OP_LOAD);
  assign hit_a   = (ex_dst == id_src_a);

  generate
    if (CMP_SRC_B) begin : g_cmp_b
      assign hit_b = (ex_dst == id_src_b);
    end else begin : g_no_cmp_b
      logic unused_b;
      assign unused_b = ^id_src_b;
      assign hit_b    = 1'b0;
    end
  endgenerate

  assign hazard = is_load && (hit_a || hit_b);
endmodule

// File: rtl/lus_idex_reg.sv
module lus_idex_reg #(
  parameter int                 W     = 32,
  parameter logic [W-1:0]       RST_V = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (en) begin
      q_nxt = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= RST_V;
    end else begin
      q_r <= q_nxt;
    end
  end

  assign q = q_r;
endmodule

// File: rtl/lus_stall_unit.sv
module lus_stall_unit
  import lus_pkg::*;
#(
  parameter int INSTR_W     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] ifid_instr,
  output logic               stall,
  output logic               pc_write_en,
  output logic               ifid_write_en,
  output logic [INSTR_W-1:0] idex_instr_nxt,
  output logic [INSTR_W-1:0] idex_instr
);
  localparam int PAD_W = INSTR_W - FMT_W;
  localparam logic [INSTR_W-1:0] BUBBLE =
    {{PAD_W{1'b0}}, OP_NOP, {(2 * REG_W + OFF_W){1'b0}}};

  logic rst_sync_n;
  logic hazard;
  logic [INSTR_W-1:0] idex_q;
  logic [INSTR_W-1:0] idex_d;

  lus_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lus_stall_detect #(.CMP_SRC_B(1'b1)) u_det (
    .ex_op    (idex_q[OP_LSB +: OP_W]),
    .ex_dst   (idex_q[REGB_LSB +: REG_W]),
    .id_src_a (ifid_instr[REGA_LSB +: REG_W]),
    .id_src_b (ifid_instr[REGB_LSB +: REG_W]),
    .hazard   (hazard)
  );

  always_comb begin
    idex_d = ifid_instr;
    if (hazard) begin
      idex_d = BUBBLE;
    end
  end

  lus_idex_reg #(.W(INSTR_W), .RST_V(BUBBLE)) u_idex (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (1'b1),
    .d     (idex_d),
    .q     (idex_q)
  );

  assign stall          = hazard;
  assign pc_write_en    = ~hazard;
  assign ifid_write_en  = ~hazard;
  assign idex_instr_nxt = idex_d;
  assign idex_instr     = idex_q;
endmodule

// File: rtl/lus_stall_unit_chk.sv
module lus_stall_unit_chk
  import lus_pkg::*;
#(
  parameter int INSTR_W = 32
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic [INSTR_W-1:0] ifid_instr,
  input logic               stall,
  input logic [INSTR_W-1:0] idex_instr
);
  localparam logic [INSTR_W-1:0] NOP_WORD =
    {{(INSTR_W - FMT_W){1'b0}}, OP_NOP, {(2 * REG_W + OFF_W){1'b0}}};

  // R8
  bubble_after_stall_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stall |=> (idex_instr == NOP_WORD));

  // R8
  word_passes_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !stall |=> (idex_instr == $past(ifid_instr)));

  // R4
  only_load_stalls_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (idex_instr[OP_LSB +: OP_W] != OP_LOAD) |-> !stall);

  // R9
  one_cycle_stall_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stall |=> !stall);

  // R5
  no_match_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((idex_instr[REGB_LSB +: REG_W] != ifid_instr[REGA_LSB +: REG_W]) &&
     (idex_instr[REGB_LSB +: REG_W] != ifid_instr[REGB_LSB +: REG_W])) |-> !stall);
endmodule

bind lus_stall_unit lus_stall_unit_chk #(.INSTR_W(INSTR_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .ifid_instr (ifid_instr),
  .stall      (stall),
  .idex_instr (idex_instr)
);

// File: tb/sim_lus_stall_unit.sv
`timescale 1ns/1ps
module sim_lus_stall_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ifid_instr = 32'h01C0_0000;
  logic        stall, pc_write_en, ifid_write_en;
  logic [31:0] idex_instr_nxt, idex_instr;

  localparam logic [31:0] NOPW = 32'h01C0_0000;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] exp_idex = NOPW;
  logic [31:0] exp_q[$];
  string       req_q[$];

  always #2.5 clk = ~clk;

  lus_stall_unit u0 (
    .clk(clk), .rst_n(rst_n), .ifid_instr(ifid_instr), .stall(stall),
    .pc_write_en(pc_write_en), .ifid_write_en(ifid_write_en),
    .idex_instr_nxt(idex_instr_nxt), .idex_instr(idex_instr)
  );

  function automatic logic [31:0] mk(int op, int a, int b, int off);
    return {7'd0, op[2:0], a[2:0], b[2:0], off[15:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] w, input string req);
    logic es;
    logic [31:0] en;
    @(negedge clk);
    ifid_instr = w;
    #1;
    es = (exp_idex[24:22] == 3'd2) &&
         ((exp_idex[18:16] == w[21:19]) || (exp_idex[18:16] == w[18:16]));
    en = es ? NOPW : w;
    chk(stall == es, req, "stall", {31'd0, stall}, {31'd0, es});
    chk(pc_write_en == !es, "R7", "pc_write_en", {31'd0, pc_write_en}, {31'd0, !es});
    chk(ifid_write_en == !es, "R7", "ifid_write_en", {31'd0, ifid_write_en}, {31'd0, !es});
    chk(idex_instr_nxt == en, "R8", "idex_instr_nxt", idex_instr_nxt, en);
    exp_q.push_back(en);
    req_q.push_back(req);
    exp_idex = en;
  endtask

  // scoreboard monitor: registered execute-stage word
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [31:0] e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      chk(idex_instr == e, r, "idex_instr", idex_instr, e);
    end
  end

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(idex_instr == NOPW, "R1", "idex in reset", idex_instr, NOPW);
    chk(stall == 1'b0, "R1", "stall in reset", {31'd0, stall}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(idex_instr == NOPW, "R1", "idex after release", idex_instr, NOPW);

    // R2: load dst matches decode first source
    step(mk(2, 0, 1, 5), "R8");
    step(mk(0, 1, 2, 3), "R2");
    step(mk(0, 1, 2, 3), "R9");
    // R3: match on second source only
    step(mk(2, 3, 4, 0), "R4");
    step(mk(1, 2, 4, 0), "R3");
    step(mk(1, 2, 4, 0), "R9");
    // R5: offset field equal to load dst is not compared
    step(mk(2, 0, 6, 0), "R8");
    step(mk(0, 0, 0, 6), "R5");
    // R6: halt and no-op decode words still compared
    step(mk(2, 0, 5, 0), "R8");
    step(mk(6, 5, 0, 0), "R6");
    step(mk(6, 5, 0, 0), "R9");
    step(mk(2, 0, 7, 0), "R8");
    step(mk(7, 0, 7, 0), "R6");
    step(mk(7, 0, 7, 0), "R9");
    // R4: store and branch with matching fields do not stall
    step(mk(3, 0, 3, 0), "R8");
    step(mk(0, 3, 3, 0), "R4");
    step(mk(4, 2, 2, 0), "R8");
    step(mk(0, 2, 2, 0), "R4");
    // R4: bubble (dst field 0) never stalls a register-0 reader
    step(mk(2, 0, 0, 0), "R8");
    step(mk(0, 0, 0, 0), "R2");
    step(mk(0, 0, 0, 0), "R4");
    // back-to-back loads
    step(mk(2, 0, 2, 0), "R8");
    step(mk(2, 2, 3, 0), "R2");
    step(mk(2, 2, 3, 0), "R9");
    step(mk(0, 3, 1, 0), "R2");
    step(mk(0, 3, 1, 0), "R9");
    step(NOPW, "R8");
    step(NOPW, "R8");
    repeat (3) @(posedge clk);
    #2;
    finish_run();
  end
endmodule